// File: doc/BRIEF.md
# Interlaced CCD Vertical Timing Generator

This block produces the digital control codes for the four vertical transfer phases of an interline-transfer CCD. It also produces the two readout strobes that lift photodiode charge into the vertical registers, a field flag for interlaced 525-line video, and a vertical blanking flag. It runs on the pixel clock. A horizontal strobe marks each line start and a vertical strobe marks each field start. The analog level shifters and clock drivers sit after it and turn each two-bit code into the low (about -9 V), middle (0 V) or high (about 15 V) rail.

An in-line timer restarts on every horizontal strobe, and a line counter restarts on every vertical strobe. On ordinary lines the phase pattern rotates through one four-phase shift. This happens inside a parameterised window in horizontal blanking, so each line moves the image down by one row. On the readout line the rotation is suppressed and two readout pulses are issued. Phase 1 and phase 3 go to the high level during these pulses. Which strobe fires first swaps between fields, so odd and even fields pair adjacent rows the opposite way round (field-integration interlace). The even field also carries one extra shift, which moves the dummy row. All windows are given in pixel-clock counts, so the 2.5 us readout width can be met at any clock rate.

Top module: `ccd_vtg`

## Requirements
- R1: While reset is held, and after it is released with no strobes, the field flag is 0, the line count is 0 (so vertical blanking is high), both readout strobes are low and the phases show the rest pattern.
- R2: A horizontal strobe sets the in-line timer to 0 at the next edge and adds one to the line count. A vertical strobe sets the line count to 0 and takes priority over a horizontal strobe in the same cycle. Without a strobe the timer counts up and holds at its all-ones value, which lies outside every window.
- R3: The field flag inverts on every vertical strobe. The value 0 denotes the odd field and 1 the even field.
- R4: Each phase is a two-bit code: low = 00, middle = 01, high = 10. Phase Vn occupies bits [2n-1:2n-2] of the level output. The rest pattern is V1 and V2 middle, V3 and V4 low (output 8'h05).
- R5: On a line other than the readout line, three consecutive windows of STEP_LEN clocks begin at timer value XFER_START. In window j (0..2) the step is k = j+1, and phase Vn is middle when ((n-1-k) mod 4) is 0 or 1, otherwise low. Outside the windows the rest pattern holds. Without a readout pulse, exactly two phases are middle.
- R6: On the readout line (line count READ_LINE) no rotation happens. Two pulse windows of RD_W clocks start at timer values RD_A_START and RD_B_START. On any other line both strobes stay low.
- R7: In the odd field strobe 1 fires in window A and strobe 2 in window B. In the even field strobe 2 fires in window A and strobe 1 in window B. The two strobes are never high together.
- R8: V1 is at the high level exactly while strobe 1 is high, and V3 exactly while strobe 2 is high. V2 and V4 never reach the high level.
- R9: In the even field only, line DUMMY_LINE carries a second rotation. It has three STEP_LEN windows starting at XFER_START + 4*STEP_LEN and uses the same k rule as R5.
- R10: Vertical blanking is high when the line count is below VBL_END or at least VBL_START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_i | input | 1 | One-cycle line-start strobe |
| vd_i | input | 1 | One-cycle field-start strobe |
| vlvl_o | output | 8 | Four two-bit phase level codes, V1 in bits 1:0 |
| sg1_o | output | 1 | Readout strobe driving V1 high |
| sg2_o | output | 1 | Readout strobe driving V3 high |
| field_o | output | 1 | Field flag, 0 odd, 1 even |
| vblank_o | output | 1 | Vertical blanking flag |

## Verification
The bench runs both field parities through the readout line. A design that failed to swap the strobe order would emit the same row pairing in both fields and lose interlace. It watches the dummy line in each field, because a missing or unconditional extra shift misaligns even fields by one row. A line cut short by an early horizontal strobe, a line long enough to saturate the timer, and a vertical strobe with no horizontal strobe check that an unrestarted or wrapping timer cannot replay a shift window. Blanking is checked at both boundary lines, where an off-by-one comparison shows.

// File: rtl/ccd_vtg_pkg.sv
package ccd_vtg_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } vlvl_e;

    typedef enum logic {
        FLD_ODD  = 1'b0,
        FLD_EVEN = 1'b1
    } fld_e;

    typedef struct packed {
        logic sg1;
        logic sg2;
    } rd_pair_t;

    localparam int NUM_PHASES = 4;
    localparam int NUM_STEPS  = 3;

    // Two adjacent phases sit at the middle level; step k moves the pair up by k.
    function automatic logic [NUM_PHASES-1:0] mid_mask(input logic [1:0] k);
        logic [7:0] dbl;
        dbl = {4'b0011, 4'b0011} << k;
        return dbl[7:4] | dbl[3:0];
    endfunction

endpackage

// File: rtl/ccd_vtg_counters.sv
module ccd_vtg_counters
    import ccd_vtg_pkg::*;
#(
    parameter int H_W    = 10,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hd_i,
    input  logic              vd_i,
    output logic [H_W-1:0]    h_o,
    output logic [LINE_W-1:0] line_o,
    output fld_e              field_o
);
    localparam logic [H_W-1:0]    H_IDLE    = {H_W{1'b1}};
    localparam logic [LINE_W-1:0] LINE_LAST = {LINE_W{1'b1}};

    logic [H_W-1:0]    h_q;
    logic [LINE_W-1:0] line_q;
    fld_e              field_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q     <= H_IDLE;
            line_q  <= '0;
            field_q <= FLD_ODD;
        end else begin
            if (hd_i)
                h_q <= '0;
            else if (h_q != H_IDLE)
                h_q <= h_q + 1'b1;

            if (vd_i) begin
                line_q  <= '0;
                field_q <= (field_q == FLD_ODD) ? FLD_EVEN : FLD_ODD;
            end else if (hd_i && line_q != LINE_LAST) begin
                line_q <= line_q + 1'b1;
            end
        end
    end

    assign h_o     = h_q;
    assign line_o  = line_q;
    assign field_o = field_q;

    assert_field_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        vd_i |=> field_q != $past(field_q));

    assert_hd_restart_R2: assert property (@(posedge clk) disable iff (rst)
        hd_i |=> h_q == '0);

    assert_vd_clears_line_R2: assert property (@(posedge clk) disable iff (rst)
        vd_i |=> line_q == '0);

endmodule

// File: rtl/ccd_vtg_xfer.sv
module ccd_vtg_xfer
    import ccd_vtg_pkg::*;
#(
    parameter int H_W        = 10,
    parameter int LINE_W     = 10,
    parameter int XFER_START = 20,
    parameter int STEP_LEN   = 16,
    parameter int READ_LINE  = 10,
    parameter int DUMMY_LINE = 9
) (
    input  logic [H_W-1:0]    h_i,
    input  logic [LINE_W-1:0] line_i,
    input  fld_e              field_i,
    output logic [1:0]        step_o
);
    localparam int DUMMY_START = XFER_START + 4 * STEP_LEN;

    logic [NUM_STEPS-1:0] hit_main;
    logic [NUM_STEPS-1:0] hit_dummy;
    logic                 on_read;
    logic                 dummy_en;

    for (genvar j = 0; j < NUM_STEPS; j++) begin : g_step
        localparam logic [H_W-1:0] M_LO = H_W'(XFER_START + j * STEP_LEN);
        localparam logic [H_W-1:0] M_HI = H_W'(XFER_START + (j + 1) * STEP_LEN);
        localparam logic [H_W-1:0] D_LO = H_W'(DUMMY_START + j * STEP_LEN);
        localparam logic [H_W-1:0] D_HI = H_W'(DUMMY_START + (j + 1) * STEP_LEN);
        assign hit_main[j]  = (h_i >= M_LO) && (h_i < M_HI);
        assign hit_dummy[j] = (h_i >= D_LO) && (h_i < D_HI);
    end

    assign on_read  = (line_i == LINE_W'(READ_LINE));
    assign dummy_en = (field_i == FLD_EVEN) && (line_i == LINE_W'(DUMMY_LINE));

    always_comb begin
        step_o = 2'd0;
        if (!on_read) begin
            for (int j = 0; j < NUM_STEPS; j++) begin
                if (hit_main[j] || (dummy_en && hit_dummy[j]))
                    step_o = 2'(j + 1);
            end
        end
    end

endmodule

// File: rtl/ccd_vtg_readout.sv
module ccd_vtg_readout
    import ccd_vtg_pkg::*;
#(
    parameter int H_W        = 10,
    parameter int LINE_W     = 10,
    parameter int READ_LINE  = 10,
    parameter int RD_A_START = 17,
    parameter int RD_B_START = 100,
    parameter int RD_W       = 36
) (
    input  logic [H_W-1:0]    h_i,
    input  logic [LINE_W-1:0] line_i,
    input  fld_e              field_i,
    output rd_pair_t          rd_o
);
    localparam logic [H_W-1:0] A_LO = H_W'(RD_A_START);
    localparam logic [H_W-1:0] A_HI = H_W'(RD_A_START + RD_W);
    localparam logic [H_W-1:0] B_LO = H_W'(RD_B_START);
    localparam logic [H_W-1:0] B_HI = H_W'(RD_B_START + RD_W);

    logic win_a, win_b, on_read;

    assign win_a   = (h_i >= A_LO) && (h_i < A_HI);
    assign win_b   = (h_i >= B_LO) && (h_i < B_HI);
    assign on_read = (line_i == LINE_W'(READ_LINE));

    // Swapping the order of the two strobes per field swaps the row pairing.
    always_comb begin
        rd_o = '0;
        if (on_read) begin
            if (field_i == FLD_EVEN) begin
                rd_o.sg1 = win_b;
                rd_o.sg2 = win_a;
            end else begin
                rd_o.sg1 = win_a;
                rd_o.sg2 = win_b;
            end
        end
    end

endmodule

// File: rtl/ccd_vtg.sv
module ccd_vtg
    import ccd_vtg_pkg::*;
#(
    parameter int H_W        = 10,
    parameter int LINE_W     = 10,
    parameter int XFER_START = 20,
    parameter int STEP_LEN   = 16,
    parameter int READ_LINE  = 10,
    parameter int DUMMY_LINE = 9,
    parameter int RD_A_START = 17,
    parameter int RD_B_START = 100,
    parameter int RD_W       = 36,
    parameter int VBL_END    = 20,
    parameter int VBL_START  = 259
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hd_i,
    input  logic       vd_i,
    output logic [7:0] vlvl_o,
    output logic       sg1_o,
    output logic       sg2_o,
    output logic       field_o,
    output logic       vblank_o
);
    logic [H_W-1:0]        h_cnt;
    logic [LINE_W-1:0]     line_cnt;
    fld_e                  field;
    logic [1:0]            step_k;
    rd_pair_t              rd;
    logic [NUM_PHASES-1:0] mid;
    logic [NUM_PHASES-1:0] is_mid;

    ccd_vtg_counters #(.H_W(H_W), .LINE_W(LINE_W)) i_cnt (
        .clk     (clk),
        .rst     (rst),
        .hd_i    (hd_i),
        .vd_i    (vd_i),
        .h_o     (h_cnt),
        .line_o  (line_cnt),
        .field_o (field)
    );

    ccd_vtg_xfer #(
        .H_W(H_W), .LINE_W(LINE_W), .XFER_START(XFER_START),
        .STEP_LEN(STEP_LEN), .READ_LINE(READ_LINE), .DUMMY_LINE(DUMMY_LINE)
    ) i_xfer (
        .h_i     (h_cnt),
        .line_i  (line_cnt),
        .field_i (field),
        .step_o  (step_k)
    );

    ccd_vtg_readout #(
        .H_W(H_W), .LINE_W(LINE_W), .READ_LINE(READ_LINE),
        .RD_A_START(RD_A_START), .RD_B_START(RD_B_START), .RD_W(RD_W)
    ) i_rd (
        .h_i     (h_cnt),
        .line_i  (line_cnt),
        .field_i (field),
        .rd_o    (rd)
    );

    assign mid = mid_mask(step_k);

    for (genvar n = 0; n < NUM_PHASES; n++) begin : g_ph
        logic  rd_here;
        vlvl_e lvl_n;
        if (n == 0) begin : g_v1
            assign rd_here = rd.sg1;
        end else if (n == 2) begin : g_v3
            assign rd_here = rd.sg2;
        end else begin : g_plain
            assign rd_here = 1'b0;
        end
        always_comb begin
            if (rd_here)
                lvl_n = LVL_HIGH;
            else if (mid[n])
                lvl_n = LVL_MID;
            else
                lvl_n = LVL_LOW;
        end
        assign vlvl_o[2*n +: 2] = lvl_n;
        assign is_mid[n]        = (vlvl_o[2*n +: 2] == LVL_MID);
    end

    assign sg1_o    = rd.sg1;
    assign sg2_o    = rd.sg2;
    assign field_o  = field;
    assign vblank_o = (line_cnt < LINE_W'(VBL_END)) || (line_cnt >= LINE_W'(VBL_START));

    assert_two_mid_R5: assert property (@(posedge clk) disable iff (rst)
        !(sg1_o || sg2_o) |-> $countones(is_mid) == 2);

    assert_even_phases_never_high_R8: assert property (@(posedge clk) disable iff (rst)
        vlvl_o[3:2] != LVL_HIGH && vlvl_o[7:6] != LVL_HIGH);

    assert_sg_on_readline_R6: assert property (@(posedge clk) disable iff (rst)
        (sg1_o || sg2_o) |-> line_cnt == LINE_W'(READ_LINE));

    assert_sg_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(sg1_o && sg2_o));

endmodule

// File: tb/test_ccd_vtg.sv
module test_ccd_vtg;
    localparam int CLK_PERIOD = 10;
    localparam int H_W = 6, LINE_W = 5;
    localparam int XS = 4, SL = 3, RL = 2, DL = 4;
    localparam int RA = 3, RB = 12, RW = 5, VE = 3, VS = 9;
    localparam int HMAX = (1 << H_W) - 1, LMAX = (1 << LINE_W) - 1;
    localparam int LINE_LEN = 30, FIELD_LINES = 11;

    logic clk = 1'b0, rst = 1'b1, hd = 1'b0, vd = 1'b0;
    logic [7:0] vlvl;
    logic sg1, sg2, fld, vbl;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ccd_vtg #(
        .H_W(H_W), .LINE_W(LINE_W), .XFER_START(XS), .STEP_LEN(SL),
        .READ_LINE(RL), .DUMMY_LINE(DL), .RD_A_START(RA), .RD_B_START(RB),
        .RD_W(RW), .VBL_END(VE), .VBL_START(VS)
    ) i_ccd_vtg (
        .clk(clk), .rst(rst), .hd_i(hd), .vd_i(vd), .vlvl_o(vlvl),
        .sg1_o(sg1), .sg2_o(sg2), .field_o(fld), .vblank_o(vbl)
    );

    typedef struct {
        logic [7:0] lvl;
        logic       s1, s2, f, vb;
        string      tag_lvl, tag_sg;
    } exp_t;

    exp_t q[$];
    int n_checks = 0, n_fail = 0;
    int m_line = 0, m_h = HMAX;
    logic m_fld = 1'b0;
    bit done = 0;

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit inwin(int h, int lo, int len);
        return h >= lo && h < lo + len;
    endfunction

    function automatic exp_t predict(string force_tag);
        exp_t e;
        int k = 0;
        bit wa, wb, dummy_hit = 0;
        e.vb = (m_line < VE) || (m_line >= VS);
        e.f  = m_fld;
        wa = inwin(m_h, RA, RW);
        wb = inwin(m_h, RB, RW);
        e.s1 = 0; e.s2 = 0;
        if (m_line == RL) begin
            e.s1 = m_fld ? wb : wa;
            e.s2 = m_fld ? wa : wb;
        end else begin
            for (int j = 0; j < 3; j++) begin
                if (inwin(m_h, XS + j * SL, SL)) k = j + 1;
                if (m_fld && m_line == DL && inwin(m_h, XS + 4 * SL + j * SL, SL)) begin
                    k = j + 1; dummy_hit = 1;
                end
            end
        end
        for (int n = 0; n < 4; n++) begin
            logic [1:0] c;
            if ((n == 0 && e.s1) || (n == 2 && e.s2)) c = 2'b10;
            else if (((n - k + 4) % 4) < 2) c = 2'b01;
            else c = 2'b00;
            e.lvl[2*n +: 2] = c;
        end
        e.tag_sg = (m_line == RL) ? "R7" : "R6";
        if (force_tag != "") e.tag_lvl = force_tag;
        else if (e.s1 || e.s2) e.tag_lvl = "R8";
        else if (m_line == RL) e.tag_lvl = "R6";
        else if (dummy_hit) e.tag_lvl = "R9";
        else if (k != 0) e.tag_lvl = "R5";
        else e.tag_lvl = "R4";
        return e;
    endfunction

    // driver: one cycle of stimulus; expected state after the next edge is queued
    task automatic step(bit h, bit v, string tag);
        @(negedge clk);
        rst = 1'b0; hd = h; vd = v;
        if (v) begin m_line = 0; m_fld = ~m_fld; end
        else if (h && m_line < LMAX) m_line++;
        if (h) m_h = 0; else if (m_h < HMAX) m_h++;
        q.push_back(predict(tag));
    endtask

    task automatic run_line(int len, bit with_vd, string tag);
        step(1'b1, with_vd, tag);
        for (int i = 1; i < len; i++) step(1'b0, 1'b0, tag);
    endtask

    // monitor: compares shortly after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag_lvl, "vlvl", vlvl, e.lvl);
            check(e.tag_sg, "sg1", sg1, e.s1);
            check(e.tag_sg, "sg2", sg2, e.s2);
            check("R3", "field", fld, e.f);
            check("R10", "vblank", vbl, e.vb);
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset vlvl", vlvl, 8'h05);
        check("R4", "rest code", vlvl, 8'h05);
        check("R1", "reset sg", {sg1, sg2}, 0);
        check("R1", "reset field", fld, 0);
        check("R1", "reset vblank", vbl, 1);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R1");
        for (int f = 0; f < 4; f++)
            for (int l = 0; l < FIELD_LINES; l++)
                run_line(LINE_LEN, l == 0, "");
        run_line(LINE_LEN, 1'b1, "");       // even field, line 0
        run_line(8, 1'b0, "R2");            // line cut short mid-rotation
        run_line(LINE_LEN, 1'b0, "R2");
        run_line(80, 1'b0, "R2");           // timer saturates
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R2");
        step(1'b0, 1'b1, "R2");             // field strobe without line strobe
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R2");
        run_line(LINE_LEN, 1'b1, "R2");     // both strobes together
        for (int l = 1; l < FIELD_LINES; l++) run_line(LINE_LEN, 1'b0, "");
        @(negedge clk); hd = 0; vd = 0;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule